// File: doc/BRIEF.md
# Watchdog Timer with Grace Window and Timed Reset Pulse

This block supervises software through a free-running 18-bit up-counter clocked by a slow watchdog clock. Software picks one of eight timeout intervals with a 3-bit code. When the counter reaches that interval, a timeout flag is set and, if software allowed it, the interrupt output goes high. The timeout also opens a grace window of 1024 clocks. Software must restart the counter within the window; otherwise, when the reset enable bit is set, the block drives a system reset pulse of exactly 63 clocks and records the event in a sticky flag. While the chip sleeps, a timeout can also raise a wake-up request.

A single control/status word carries all fields. It is written with `wr_en` and `wr_data` and read back combinationally on `rd_data`. Bit positions: [0] run, [1] interrupt enable, [2] reset enable, [3] wake enable, [6:4] interval code, [7] counter clear (kick), [8] timeout flag, [9] reset flag. The sequencing is a four-state machine:

- IDLE: counter stopped or just started. It leaves for COUNT once run is set.
- COUNT: counter running, no timeout pending. A timeout moves it to GRACE.
- GRACE: the window is open. A kick returns it to COUNT. When the window expires it goes to RESET if reset is enabled, and to COUNT if not.
- RESET: the pulse is active. After 63 clocks it returns to IDLE.

A write with run cleared sends any state to IDLE.

Top module: `wdog_delayed_reset`

## Requirements
- R1: After `rst_n` is asserted, every field of `rd_data` except bit [9] reads 0, and `irq`, `sys_rst` and `wake` are low.
- R2: With run set at a write edge and interval code `s` in bits [6:4], the timeout flag (bit [8]) is set exactly 2^(4+2·s) clock edges after that write, and not earlier.
- R3: The timeout flag is set on a timeout whether or not interrupts are enabled. `irq` is high exactly while bit [8] and bit [1] are both 1.
- R4: Writing 1 to bit [8] or bit [9] clears that flag. If a hardware set happens at the same edge, the flag stays 1.
- R5: If no kick arrives and bit [2] is 1, `sys_rst` rises exactly 1024 clocks after the edge that set the timeout flag.
- R6: `sys_rst` stays high for exactly 63 clocks. It sets bit [9] as it rises, and when it ends the run bit reads 0.
- R7: A write with bit [7] set zeroes the counter and closes an open grace window, so no reset follows. Bit [7] reads 1 for one cycle after that write and then 0.
- R8: With bit [2] at 0, the end of the grace window produces no reset and leaves bit [9] unchanged.
- R9: While `pwr_down` is high and bit [3] is 1, a timeout raises `wake`. `wake` stays high until one edge after `pwr_down` falls.
- R10: A write with bit [0] at 0 stops the counter and cancels any open grace window or reset pulse. No further timeouts occur until the block is re-enabled.
- R11: Bit [9] is kept through `rst_n` and is cleared only by `por_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low register reset (keeps the reset flag) |
| por_n | input | 1 | Asynchronous active-low power-on reset (clears the reset flag) |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 10 | Control word written on `wr_en` |
| pwr_down | input | 1 | High while the chip is powered down |
| rd_data | output | 10 | Current control/status word |
| irq | output | 1 | Timeout interrupt |
| sys_rst | output | 1 | System reset pulse, active high |
| wake | output | 1 | Wake-up request |

## Verification
The shortest interval code is run with interrupts disabled and then enabled, which separates setting the flag from raising the interrupt. A longer code is used to confirm that the interval scales with the code. One grace window is left to expire with reset enabled and another with reset disabled, which separates the two exits from GRACE. A kick placed in the middle of a window shows that the window is cancelled, not merely delayed. A flag clear timed onto a timeout edge exposes a reversed set/clear priority. Register-only and power-on resets are applied in turn after a real reset pulse, which shows which of them the sticky flag survives.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_GRACE,
        ST_RESET
    } wdg_state_e;

    localparam int SEL_W    = 3;
    localparam int F_RUN    = 0;
    localparam int F_IRQEN  = 1;
    localparam int F_RSTEN  = 2;
    localparam int F_WAKEEN = 3;
    localparam int F_SEL_LO = 4;
    localparam int F_KICK   = 7;
    localparam int F_TOF    = 8;
    localparam int F_RSF    = 9;
    localparam int REG_W    = 10;
endpackage

// File: rtl/wdg_interval_match.sv
module wdg_interval_match #(
    parameter int CNT_W    = 18,
    parameter int SEL_W    = 3,
    parameter int BASE_LOG = 4,
    parameter int STEP_LOG = 2
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [SEL_W-1:0] sel,
    output logic             match
);
    localparam int NSEL = 1 << SEL_W;

    logic [CNT_W-1:0] masks [NSEL];

    for (genvar i = 0; i < NSEL; i++) begin : g_mask
        localparam int RAW  = BASE_LOG + STEP_LOG * i;
        localparam int LOGI = (RAW > CNT_W) ? CNT_W : RAW;
        assign masks[i] = {CNT_W{1'b1}} >> (CNT_W - LOGI);
    end

    // All low bits of the counter at one: the last count of an interval
    assign match = (cnt & masks[sel]) == masks[sel];
endmodule

// File: rtl/wdg_span_counter.sv
module wdg_span_counter #(
    parameter int LEN = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int W = (LEN > 2) ? $clog2(LEN) : 1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + W'(1);
    end

    assign done = run && (cnt_q == W'(LEN - 1));
endmodule

// File: rtl/wdog_delayed_reset.sv
module wdog_delayed_reset
    import wdg_pkg::*;
#(
    parameter int CNT_W     = 18,
    parameter int BASE_LOG  = 4,
    parameter int STEP_LOG  = 2,
    parameter int GRACE_CYC = 1024,
    parameter int PULSE_CYC = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             pwr_down,
    output logic [REG_W-1:0] rd_data,
    output logic             irq,
    output logic             sys_rst,
    output logic             wake
);
    wdg_state_e       state_q, state_d;
    logic             run_q, irq_en_q, rst_en_q, wake_en_q;
    logic [SEL_W-1:0] sel_q;
    logic             kick_q, tof_q, rsf_q, wake_q;
    logic [CNT_W-1:0] cnt_q;
    logic             kick_w, stop_w, match, hit;
    logic             grace_done, pulse_done;

    assign kick_w = wr_en && wr_data[F_KICK];
    assign stop_w = wr_en && !wr_data[F_RUN];
    assign hit    = run_q && match && !kick_w;

    wdg_interval_match #(
        .CNT_W   (CNT_W),
        .SEL_W   (SEL_W),
        .BASE_LOG(BASE_LOG),
        .STEP_LOG(STEP_LOG)
    ) u_match (
        .cnt  (cnt_q),
        .sel  (sel_q),
        .match(match)
    );

    wdg_span_counter #(.LEN(GRACE_CYC)) u_grace (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q == ST_GRACE),
        .done (grace_done)
    );

    wdg_span_counter #(.LEN(PULSE_CYC)) u_pulse (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q == ST_RESET),
        .done (pulse_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_w) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (run_q) state_d = ST_COUNT;
                ST_COUNT: if (hit) state_d = ST_GRACE;
                ST_GRACE: begin
                    if (kick_w)
                        state_d = ST_COUNT;
                    else if (grace_done)
                        state_d = rst_en_q ? ST_RESET : ST_COUNT;
                end
                ST_RESET: if (pulse_done) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Control fields, counter, timeout flag and wake request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            irq_en_q  <= 1'b0;
            rst_en_q  <= 1'b0;
            wake_en_q <= 1'b0;
            sel_q     <= '0;
            kick_q    <= 1'b0;
            tof_q     <= 1'b0;
            wake_q    <= 1'b0;
            cnt_q     <= '0;
        end else begin
            kick_q <= kick_w;
            if (pulse_done)
                run_q <= 1'b0;
            else if (wr_en)
                run_q <= wr_data[F_RUN];
            if (wr_en) begin
                irq_en_q  <= wr_data[F_IRQEN];
                rst_en_q  <= wr_data[F_RSTEN];
                wake_en_q <= wr_data[F_WAKEEN];
                sel_q     <= wr_data[F_SEL_LO +: SEL_W];
            end
            if (hit)
                tof_q <= 1'b1;
            else if (wr_en && wr_data[F_TOF])
                tof_q <= 1'b0;
            if (kick_w || pulse_done)
                cnt_q <= '0;
            else if (run_q)
                cnt_q <= cnt_q + CNT_W'(1);
            if (!pwr_down)
                wake_q <= 1'b0;
            else if (hit && wake_en_q)
                wake_q <= 1'b1;
        end
    end

    // Sticky reset-source flag: only the power-on reset clears it
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rsf_q <= 1'b0;
        end else if (rst_n) begin
            if (state_d == ST_RESET && state_q != ST_RESET)
                rsf_q <= 1'b1;
            else if (wr_en && wr_data[F_RSF])
                rsf_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        sys_rst = (state_q == ST_RESET);
        irq     = tof_q && irq_en_q;
        wake    = wake_q;
        rd_data = '0;
        rd_data[F_RUN]                = run_q;
        rd_data[F_IRQEN]              = irq_en_q;
        rd_data[F_RSTEN]              = rst_en_q;
        rd_data[F_WAKEEN]             = wake_en_q;
        rd_data[F_SEL_LO +: SEL_W]    = sel_q;
        rd_data[F_KICK]               = kick_q;
        rd_data[F_TOF]                = tof_q;
        rd_data[F_RSF]                = rsf_q;
    end
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic wr_run,
    input logic wr_kick,
    input logic pwr_down,
    input logic rd_run,
    input logic rd_kick,
    input logic rd_rflag,
    input logic sys_rst,
    input logic wake
);
    // R6: the reset flag is set as the pulse starts
    a_r6_flag_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst) |-> rd_rflag);

    // R6: once the pulse ends, the watchdog is no longer running
    a_r6_run_off_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> !rd_run);

    // R7: a kick write is visible for one cycle
    a_r7_kick_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kick) |=> rd_kick);

    // R7: the kick bit clears itself
    a_r7_kick_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_kick && !(wr_en && wr_kick)) |=> !rd_kick);

    // R9: wake drops one edge after power-down ends
    a_r9_wake_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_down |=> !wake);

    // R10: disabling silences the reset output
    a_r10_stop_silences: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_run) |=> !sys_rst);
endmodule

bind wdog_delayed_reset wdg_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_run  (wr_data[0]),
    .wr_kick (wr_data[7]),
    .pwr_down(pwr_down),
    .rd_run  (rd_data[0]),
    .rd_kick (rd_data[7]),
    .rd_rflag(rd_data[9]),
    .sys_rst (sys_rst),
    .wake    (wake)
);

// File: tb/sim_wdog_delayed_reset.sv
module sim_wdog_delayed_reset;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [9:0] wr_data = '0;
    logic       pwr_down = 1'b0;
    logic [9:0] rd_data;
    logic       irq, sys_rst, wake;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    wdog_delayed_reset u0 (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en(wr_en), .wr_data(wr_data),
        .pwr_down(pwr_down), .rd_data(rd_data), .irq(irq), .sys_rst(sys_rst), .wake(wake)
    );

    // Behavioural reference model (state: 0 idle, 1 count, 2 grace, 3 reset)
    int m_run, m_irqen, m_rsten, m_wken, m_sel, m_kick, m_tof, m_rsf, m_wake;
    int m_cnt, m_st, m_g, m_p;

    always @(posedge clk or negedge rst_n or negedge por_n) begin
        int iv, nst;
        bit kw, dw, hit, gd, pd;
        if (!por_n) m_rsf = 0;
        if (!rst_n) begin
            m_run = 0; m_irqen = 0; m_rsten = 0; m_wken = 0; m_sel = 0;
            m_kick = 0; m_tof = 0; m_wake = 0; m_cnt = 0; m_st = 0; m_g = 0; m_p = 0;
        end else begin
            iv  = 1 << (4 + 2 * m_sel);
            kw  = wr_en && wr_data[7];
            dw  = wr_en && !wr_data[0];
            hit = (m_run != 0) && (m_cnt % iv == iv - 1) && !kw;
            gd  = (m_st == 2) && (m_g == 1023);
            pd  = (m_st == 3) && (m_p == 62);
            nst = m_st;
            if (dw) nst = 0;
            else case (m_st)
                0: if (m_run != 0) nst = 1;
                1: if (hit) nst = 2;
                2: if (kw) nst = 1; else if (gd) nst = (m_rsten != 0) ? 3 : 1;
                3: if (pd) nst = 0;
                default: nst = 0;
            endcase
            if (nst == 3 && m_st != 3) m_rsf = 1;
            else if (wr_en && wr_data[9]) m_rsf = 0;
            if (hit) m_tof = 1;
            else if (wr_en && wr_data[8]) m_tof = 0;
            m_wake = !pwr_down ? 0 : ((m_wake != 0 || (hit && m_wken != 0)) ? 1 : 0);
            m_g = (m_st == 2) ? (m_g + 1) % 1024 : 0;
            m_p = (m_st == 3) ? (m_p + 1) % 64 : 0;
            if (kw || pd) m_cnt = 0;
            else if (m_run != 0) m_cnt = (m_cnt + 1) % (1 << 18);
            if (pd) m_run = 0;
            else if (wr_en) m_run = wr_data[0];
            if (wr_en) begin
                m_irqen = wr_data[1]; m_rsten = wr_data[2];
                m_wken = wr_data[3]; m_sel = int'(wr_data[6:4]);
            end
            m_kick = kw ? 1 : 0;
            m_st = nst;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] model_rd();
        logic [9:0] v;
        v[0] = m_run[0]; v[1] = m_irqen[0]; v[2] = m_rsten[0]; v[3] = m_wken[0];
        v[6:4] = m_sel[2:0]; v[7] = m_kick[0]; v[8] = m_tof[0]; v[9] = m_rsf[0];
        return v;
    endfunction

    // Compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R3 model irq", 32'(irq), 32'(m_tof != 0 && m_irqen != 0));
            chk("R5 model sys_rst", 32'(sys_rst), 32'(m_st == 3));
            chk("R9 model wake", 32'(wake), 32'(m_wake != 0));
            chk("R2 model rd_data", 32'(rd_data), 32'(model_rd()));
        end
    end

    function automatic logic [9:0] ctl(input bit run, input bit ie, input bit re, input bit we,
                                       input int sel, input bit kick, input bit ctof, input bit crsf);
        logic [9:0] v;
        v = '0;
        v[0] = run; v[1] = ie; v[2] = re; v[3] = we; v[6:4] = sel[2:0];
        v[7] = kick; v[8] = ctof; v[9] = crsf;
        return v;
    endfunction

    task automatic wr(input logic [9:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        #2 rst_n = 1'b1; por_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;
        // R1 reset state
        chk("R1 rd_data after reset", 32'(rd_data), 0);
        chk("R1 outputs after reset", 32'({irq, sys_rst, wake}), 0);

        // R2/R3: shortest interval with interrupt enabled
        wr(ctl(1, 1, 0, 0, 0, 0, 0, 0));
        wait_cyc(15);
        chk("R2 no timeout before 16 clocks", 32'(rd_data[8]), 0);
        chk("R3 irq low before timeout", 32'(irq), 0);
        wait_cyc(1);
        chk("R2 timeout at 16 clocks", 32'(rd_data[8]), 1);
        chk("R3 irq high on timeout", 32'(irq), 1);

        // R10: stop and clear flag (R4)
        wr(ctl(0, 1, 0, 0, 0, 0, 1, 0));
        chk("R4 flag cleared by write", 32'(rd_data[8]), 0);
        wait_cyc(100);
        chk("R10 no timeout while stopped", 32'(rd_data[8]), 0);

        // R3: interrupt disabled, flag still sets
        wr(ctl(1, 0, 0, 0, 0, 1, 1, 0));
        wait_cyc(16);
        chk("R3 flag sets with irq disabled", 32'(rd_data[8]), 1);
        chk("R3 irq stays low when disabled", 32'(irq), 0);
        wr(ctl(1, 1, 0, 0, 0, 0, 0, 0));
        chk("R3 irq follows enable", 32'(irq), 1);

        // R4: hardware set wins over a clear at the same edge
        wr(ctl(1, 1, 0, 0, 0, 1, 1, 0));
        wait_cyc(15);
        wr(ctl(1, 1, 0, 0, 0, 0, 1, 0));
        chk("R4 set beats clear", 32'(rd_data[8]), 1);
        wr(ctl(1, 1, 0, 0, 0, 0, 1, 0));
        chk("R4 clear after set", 32'(rd_data[8]), 0);

        // R8: window expires with reset disabled
        wait_cyc(1100);
        chk("R8 no reset when disabled", 32'(sys_rst), 0);
        chk("R8 reset flag untouched", 32'(rd_data[9]), 0);

        // R5/R6: full reset sequence
        wr(ctl(1, 0, 1, 0, 0, 1, 1, 0));
        wait_cyc(16);
        chk("R5 timeout opens window", 32'(rd_data[8]), 1);
        wait_cyc(1023);
        chk("R5 no reset before 1024 clocks", 32'(sys_rst), 0);
        wait_cyc(1);
        chk("R5 reset at 1024 clocks", 32'(sys_rst), 1);
        chk("R6 reset flag set", 32'(rd_data[9]), 1);
        wait_cyc(62);
        chk("R6 pulse still high at 63rd clock", 32'(sys_rst), 1);
        wait_cyc(1);
        chk("R6 pulse ends after 63 clocks", 32'(sys_rst), 0);
        chk("R6 run cleared after pulse", 32'(rd_data[0]), 0);

        // R11: register reset keeps flag, power-on reset clears it
        #2 rst_n = 1'b0;
        wait_cyc(2);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk("R11 flag survives register reset", 32'(rd_data[9]), 1);
        chk("R1 other fields reset", 32'(rd_data[8:0]), 0);
        #2 por_n = 1'b0; rst_n = 1'b0;
        wait_cyc(2);
        #2 por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        chk("R11 flag cleared by power-on reset", 32'(rd_data[9]), 0);

        // R7: kick inside the window cancels the reset
        wr(ctl(1, 0, 1, 0, 0, 0, 0, 0));
        wait_cyc(516);
        wr(ctl(1, 0, 1, 0, 0, 1, 0, 0));
        chk("R7 kick bit reads one", 32'(rd_data[7]), 1);
        wait_cyc(1);
        chk("R7 kick bit self clears", 32'(rd_data[7]), 0);
        wait_cyc(600);
        chk("R7 no reset after kick", 32'(sys_rst), 0);
        chk("R7 reset flag still clear", 32'(rd_data[9]), 0);

        // R10: disable cancels the open window
        wr(ctl(0, 0, 1, 0, 0, 0, 1, 0));
        wait_cyc(1200);
        chk("R10 disable cancels reset", 32'(sys_rst), 0);
        chk("R10 no new timeout", 32'(rd_data[8]), 0);

        // R9 and R2 with code 1 (64 clocks)
        pwr_down = 1'b1;
        wr(ctl(1, 0, 0, 1, 1, 1, 1, 0));
        wait_cyc(63);
        chk("R2 code 1 no timeout at 63", 32'(rd_data[8]), 0);
        chk("R9 wake low before timeout", 32'(wake), 0);
        wait_cyc(1);
        chk("R2 code 1 timeout at 64", 32'(rd_data[8]), 1);
        chk("R9 wake on timeout", 32'(wake), 1);
        pwr_down = 1'b0;
        wait_cyc(1);
        chk("R9 wake drops after power-down", 32'(wake), 0);
        wr(ctl(0, 0, 0, 0, 0, 0, 1, 0));
        wait_cyc(4);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule